// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers single-cycle event pulses from a network controller's receive path, transmit path and bus error detectors into one sticky status word. Each event sets its own status bit, and that bit stays set until software reads the status word. The read returns the word and clears it in the same access. A separate mask word chooses which status bits may raise the interrupt. A single global enable bit gates the interrupt line as a whole.

One status position holds no event of its own. It is a summary flag: it is set whenever any of the error-class bits in the band 16 to 25 is set, so software can test one bit before it decodes the upper band. Software reaches the three registers through a small synchronous port. Each read returns its data one cycle after the request. The interrupt line is registered.

Status bit map (event input bit i sets status bit i): 0 rx good, 1 rx descriptor done, 2 rx error, 3 rx early, 4 rx idle, 5 rx overrun, 6 tx good, 7 tx descriptor done, 8 tx error, 9 tx idle, 10 tx underrun, 11 counter service, 12 software request, 13 power event, 14 PHY, 15 summary, 16 rx status overflow, 20 target abort, 21 master abort, 22 system error, 23 parity error, 24 rx reset done, 25 tx reset done. Register addresses: 0 status, 1 mask, 2 enable, 3 unused (reads zero).

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous reset, the status, mask and enable registers are zero, `irq_o` is low and `rdata_o` is zero.
- R2: A pulse on `evt_i[i]` for a defined position i (0-14, 16, 20-25) sets status bit i at the next clock edge. The bit then stays set until the status register is read.
- R3: A read of address 0 returns the status word on `rdata_o` in the cycle after the request, and clears every stored status bit at that same edge.
- R4: An event pulse in the same cycle as a status read is absent from the returned value, but it is set in the status register after the read.
- R5: Status bit 15 reads as the OR of status bits 25 down to 16. `evt_i[15]` has no effect.
- R6: Status positions 17-19 and all positions above 25 read as zero, and events on bits 17-19 are ignored. Writes to address 0 change nothing. A read of address 3 returns zero.
- R7: A write to address 1 stores the mask. Only bits 0-16 and 20-25 are kept, and a read of address 1 returns the stored mask in the next cycle.
- R8: Bit 0 of address 2 is the global enable and reads back as bit 0. One cycle after the enable and the OR of (visible status AND mask) are both true, `irq_o` is high. Otherwise it is low one cycle later.
- R9: While the global enable is clear, `irq_o` stays low whatever status and mask hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | EVT_W (26) | Event pulses, one per status position |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register select: 0 status, 1 mask, 2 enable |
| wdata_i | input | EVT_W (26) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data, valid the cycle after `rd_i` |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The bench first drives isolated pulses, then drives them again across a status read. The isolated pulses show that the bits are sticky and are cleared by the read. The pulses across a read show whether an event landing in the read cycle is kept or dropped. Pulses confined to the upper band, and a pulse on the summary position alone, show the derived summary apart from a stored bit. Mask and enable are then set in turn, so that a masked-off bit, a disabled line and a fully enabled bit each give a distinct interrupt result. A long run of random events, reads and writes is compared against a behavioural model on every clock to catch same-cycle ordering errors.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int EVT_W    = 26;
  localparam int DATA_W   = 32;
  localparam int SUM_BIT  = 15;
  localparam int SUM_LO   = 16;
  localparam int SUM_HI   = 25;
  // positions that hold a real event flag
  localparam logic [EVT_W-1:0] STORE_BITS = 26'h3F17FFF;
  // positions the mask may hold (event flags plus the summary flag)
  localparam logic [EVT_W-1:0] MASK_BITS  = STORE_BITS | (26'h1 << SUM_BIT);

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_MASK = 2'd1,
    SEL_EN   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_evt_capture.sv
module irq_evt_capture #(
  parameter int EVT_W = irq_pkg::EVT_W,
  parameter logic [EVT_W-1:0] STORE_BITS = irq_pkg::STORE_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             clr_i,
  output logic [EVT_W-1:0] stat_o
);
  logic [EVT_W-1:0] stat_q;
  logic [EVT_W-1:0] evt_keep;

  assign evt_keep = evt_i & STORE_BITS;

  // clear and capture share one edge, so a same-cycle event survives
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (clr_i ? '0 : stat_q) | evt_keep;
  end

  assign stat_o = stat_q;

  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

  a_r3_clear_on_read: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (stat_o == ($past(evt_i) & STORE_BITS)));
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int EVT_W   = irq_pkg::EVT_W,
  parameter int SUM_BIT = irq_pkg::SUM_BIT,
  parameter int SUM_LO  = irq_pkg::SUM_LO,
  parameter int SUM_HI  = irq_pkg::SUM_HI
) (
  input  logic [EVT_W-1:0] stat_i,
  output logic [EVT_W-1:0] view_o
);
  logic band_any;

  assign band_any = |stat_i[SUM_HI:SUM_LO];

  for (genvar i = 0; i < EVT_W; i++) begin : g_view
    if (i == SUM_BIT) begin : g_sum
      assign view_o[i] = band_any | stat_i[i];
    end else begin : g_pass
      assign view_o[i] = stat_i[i];
    end
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int EVT_W  = irq_pkg::EVT_W,
  parameter int DATA_W = irq_pkg::DATA_W,
  parameter logic [EVT_W-1:0] MASK_BITS = irq_pkg::MASK_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [EVT_W-1:0]  wdata_i,
  input  logic [EVT_W-1:0]  view_i,
  output logic              stat_rd_o,
  output logic [EVT_W-1:0]  mask_o,
  output logic              en_o,
  output logic [DATA_W-1:0] rdata_o
);
  import irq_pkg::*;

  localparam int PAD_W = DATA_W - EVT_W;

  reg_sel_e         sel;
  logic [EVT_W-1:0] mask_q;
  logic             en_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign sel       = reg_sel_e'(addr_i);
  assign stat_rd_o = rd_i && (sel == SEL_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_i) begin
      if (sel == SEL_MASK) mask_q <= wdata_i & MASK_BITS;
      if (sel == SEL_EN)   en_q   <= wdata_i[0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_STAT: rd_mux = {{PAD_W{1'b0}}, view_i};
      SEL_MASK: rd_mux = {{PAD_W{1'b0}}, mask_q};
      SEL_EN:   rd_mux = {{(DATA_W-1){1'b0}}, en_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign mask_o  = mask_q;
  assign en_o    = en_q;
  assign rdata_o = rdata_q;

  a_r7_mask_write: assert property (@(posedge clk) disable iff (rst)
    (wr_i && sel == SEL_MASK) |=> (mask_o == ($past(wdata_i) & MASK_BITS)));
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
  parameter int EVT_W = irq_pkg::EVT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] view_i,
  input  logic [EVT_W-1:0] mask_i,
  input  logic             en_i,
  output logic             irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= en_i & (|(view_i & mask_i));
  end

  assign irq_o = irq_q;

  a_r9_gate: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !irq_o);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int EVT_W   = irq_pkg::EVT_W,
  parameter int DATA_W  = irq_pkg::DATA_W,
  parameter int SUM_BIT = irq_pkg::SUM_BIT,
  parameter int SUM_LO  = irq_pkg::SUM_LO,
  parameter int SUM_HI  = irq_pkg::SUM_HI,
  parameter logic [EVT_W-1:0] STORE_BITS = irq_pkg::STORE_BITS,
  parameter logic [EVT_W-1:0] MASK_BITS  = irq_pkg::MASK_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [EVT_W-1:0]  wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [EVT_W-1:0] stat;
  logic [EVT_W-1:0] view;
  logic [EVT_W-1:0] mask;
  logic             en;
  logic             stat_rd;

  irq_evt_capture #(.EVT_W(EVT_W), .STORE_BITS(STORE_BITS)) u_cap (
    .clk(clk), .rst(rst), .evt_i(evt_i), .clr_i(stat_rd), .stat_o(stat));

  irq_summary #(.EVT_W(EVT_W), .SUM_BIT(SUM_BIT), .SUM_LO(SUM_LO),
                .SUM_HI(SUM_HI)) u_sum (
    .stat_i(stat), .view_o(view));

  irq_ctrl_regs #(.EVT_W(EVT_W), .DATA_W(DATA_W), .MASK_BITS(MASK_BITS)) u_regs (
    .clk(clk), .rst(rst), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .view_i(view), .stat_rd_o(stat_rd), .mask_o(mask),
    .en_o(en), .rdata_o(rdata_o));

  irq_line_gen #(.EVT_W(EVT_W)) u_line (
    .clk(clk), .rst(rst), .view_i(view), .mask_i(mask), .en_i(en),
    .irq_o(irq_o));

  a_r5_summary: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (rdata_o[SUM_BIT] == (|rdata_o[SUM_HI:SUM_LO])));

  a_r6_undef_zero: assert property (@(posedge clk) disable iff (rst)
    (rdata_o[DATA_W-1:EVT_W] == '0) && ((rdata_o[EVT_W-1:0] & ~MASK_BITS) == '0));

  a_r8_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (en && |(view & mask)) |=> irq_o);
endmodule

// File: tb/test_irq_status_unit.sv
`timescale 1ns/1ps
module test_irq_status_unit;
  localparam int EW = 26;
  localparam logic [31:0] STORE = 32'h03F17FFF;
  localparam logic [31:0] MDEF  = 32'h03F1FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [EW-1:0] evt = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [EW-1:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [31:0] m_stat = 0, m_mask = 0, m_rdata = 0;
  logic m_en = 0, m_irq = 0;

  always #2.5 clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  function automatic logic [31:0] vis(input logic [31:0] s);
    return s | ((|s[25:16]) ? 32'h8000 : 32'h0);
  endfunction

  always @(posedge clk) begin
    logic [31:0] v;
    if (rst) begin
      m_stat = 0; m_mask = 0; m_en = 0; m_irq = 0; m_rdata = 0;
    end else begin
      v = vis(m_stat);
      m_irq = m_en && ((v & m_mask) != 0);
      if (rd) begin
        case (addr)
          2'd0: m_rdata = v;
          2'd1: m_rdata = m_mask;
          2'd2: m_rdata = {31'd0, m_en};
          default: m_rdata = 0;
        endcase
      end
      m_stat = ((rd && addr == 2'd0) ? 32'd0 : m_stat) | ({6'd0, evt} & STORE);
      if (wr && addr == 2'd1) m_mask = {6'd0, wdata} & MDEF;
      if (wr && addr == 2'd2) m_en = wdata[0];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(cur_req, rdata, m_rdata);
      chk(cur_req, {31'd0, irq}, {31'd0, m_irq});
    end
    if (cyc > 100000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic idle();
    evt = '0; wr = 0; rd = 0;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [EW-1:0] e);
    evt = e; wr = 0; rd = 0;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic rreg(input logic [1:0] a, input logic [EW-1:0] e);
    addr = a; rd = 1; wr = 0; evt = e;
    @(negedge clk);
    rd = 0; evt = '0;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [EW-1:0] d);
    addr = a; wdata = d; wr = 1; rd = 0;
    @(negedge clk);
    wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1", rdata, 32'h0);
    chk("R1", {31'd0, irq}, 32'h0);
    rreg(2'd0, '0); chk("R1", rdata, 32'h0);
    rreg(2'd1, '0); chk("R1", rdata, 32'h0);
    rreg(2'd2, '0); chk("R1", rdata, 32'h0);

    // R2: sticky bits
    cur_req = "R2";
    pulse(26'h41); idle(); pulse(26'h1); idle();
    rreg(2'd0, '0); chk("R2", rdata, 32'h41);
    // R3: cleared by read
    cur_req = "R3";
    rreg(2'd0, '0); chk("R3", rdata, 32'h0);

    // R4: event during read kept
    cur_req = "R4";
    pulse(26'h4);
    rreg(2'd0, 26'h80); chk("R4", rdata, 32'h4);
    rreg(2'd0, '0); chk("R4", rdata, 32'h80);

    // R5: summary bit
    cur_req = "R5";
    pulse(26'h0200000);
    rreg(2'd0, '0); chk("R5", rdata, 32'h00208000);
    pulse(26'h8000);
    rreg(2'd0, '0); chk("R5", rdata, 32'h0);
    pulse(26'h2000000);
    rreg(2'd0, '0); chk("R5", rdata, 32'h02008000);

    // R6: undefined positions and status writes
    cur_req = "R6";
    pulse(26'h000E0000);
    rreg(2'd0, '0); chk("R6", rdata, 32'h0);
    wreg(2'd0, '1);
    rreg(2'd0, '0); chk("R6", rdata, 32'h0);
    rreg(2'd3, '0); chk("R6", rdata, 32'h0);

    // R7: mask storage
    cur_req = "R7";
    wreg(2'd1, '1);
    rreg(2'd1, '0); chk("R7", rdata, 32'h03F1FFFF);
    wreg(2'd1, 26'h4);
    rreg(2'd1, '0); chk("R7", rdata, 32'h4);

    // R9: no irq while disabled
    cur_req = "R9";
    pulse(26'h4); idle(); idle();
    chk("R9", {31'd0, irq}, 32'h0);

    // R8: enable raises irq one cycle later, read drops it
    cur_req = "R8";
    wreg(2'd2, 26'h1);
    chk("R8", {31'd0, irq}, 32'h0);
    idle(); chk("R8", {31'd0, irq}, 32'h1);
    rreg(2'd2, '0); chk("R8", rdata, 32'h1);
    rreg(2'd0, '0); chk("R8", rdata, 32'h4);
    idle(); chk("R8", {31'd0, irq}, 32'h0);
    // masked-off bit does not raise
    pulse(26'h1); idle(); chk("R8", {31'd0, irq}, 32'h0);
    // summary through mask bit 15
    wreg(2'd1, 26'h8000);
    pulse(26'h100000); idle(); chk("R8", {31'd0, irq}, 32'h1);
    rreg(2'd0, '0); idle(); idle(); chk("R8", {31'd0, irq}, 32'h0);

    // random traffic, compared every clock
    for (int k = 0; k < 2000; k++) begin
      evt   = ($urandom % 4 == 0) ? EW'($urandom) : '0;
      rd    = ($urandom % 3 == 0);
      wr    = !rd && ($urandom % 5 == 0);
      addr  = 2'($urandom);
      wdata = EW'($urandom);
      @(negedge clk);
    end
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule